// File: doc/BRIEF.md
# Grouped Shared Interrupt Aggregator

The aggregator gathers 22 interrupt sources into one sticky pending word and divides that word into four fixed, contiguous bit groups. Each group has its own output line toward a parent interrupt controller. A group's line stays high as long as any enabled pending bit inside its range is set. Software can therefore service a group by looping until its slice of the pending word reads zero.

A single-cycle register port gives access to two registers. The pending word sits at byte offset 0x04. Reads return the pending bits, and writes to the same offset clear every bit written as zero. The enable register sits at 0x08 and covers only the lowest group (bits 0 to 6), where a zero enables a source and a one disables it. The three upper groups have no enable and always pass their sources through.

Reads return data one cycle after the request, qualified by a valid strobe. The port runs a two-state machine: PORT_IDLE moves to PORT_RESP on a read request, PORT_RESP moves back to PORT_IDLE when no read request is present, and it stays in PORT_RESP for back-to-back reads. A write keeps the machine in, or returns it to, PORT_IDLE.

Top module: `grp_irq_top`

## Requirements
- R1: After reset the pending word reads 0, the enable register (offset 0x08) reads 0x7F (lowest group disabled), and all four group outputs are low.
- R2: A rising edge on an enabled source sets its pending bit at the first clock edge that samples the source high. The bit stays set after the source returns low.
- R3: Group output bit g of irq_o is high exactly when an enabled pending bit lies in its range. The ranges are g0 = bits 0..6, g1 = bits 7..9, g2 = bit 10 and g3 = bits 11..21.
- R4: A write to offset 0x04 clears each pending bit whose data bit is 0 and leaves each bit written as 1 unchanged.
- R5: If a source edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: Enable bits 0..6 at offset 0x08 are active low. A disabled source neither sets its pending bit nor drives irq_o[0]. A bit that is already pending but then disabled stops driving irq_o[0] and stays pending.
- R7: Sources 7..21 are always enabled. Enable data bits 7..31 are not stored, and those sources reach the pending word and their outputs whatever value is written there.
- R8: Bits 22..31 of every read are zero. Reads of any offset other than 0x04 and 0x08 return zero. Writes to other offsets change nothing.
- R9: Every read request gives rsp_valid high with its data in the following cycle, including back-to-back reads. A write never raises rsp_valid.
- R10: A source held high sets its bit only once. After a clear, the bit stays clear until the source falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 22 | Interrupt source levels |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 4 | One output line per group to the parent controller |

## Verification
A source edge or a register write driven before a clock edge shows up on the pending word and on irq_o right after that same edge. The bench drives each stimulus just after a falling edge and checks irq_o at the next falling edge. Read data is due one cycle after the request. The driver queues each expected word together with its requirement, and a monitor pops the queue at every falling edge where rsp_valid is high. Any strobe the monitor sees with the queue empty counts as a failure.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

    localparam int NUM_SRC = 22;
    localparam int NUM_GRP = 4;
    localparam int EN_W    = 7;

    localparam logic [7:0] OFS_PEND   = 8'h04;
    localparam logic [7:0] OFS_ENABLE = 8'h08;

    typedef enum logic {
        PORT_IDLE,
        PORT_RESP
    } port_state_e;

    function automatic int grp_lo(input int g);
        case (g)
            0:       return 0;
            1:       return 7;
            2:       return 10;
            default: return 11;
        endcase
    endfunction

    function automatic int grp_hi(input int g);
        case (g)
            0:       return 6;
            1:       return 9;
            2:       return 10;
            default: return 21;
        endcase
    endfunction

endpackage

// File: rtl/grp_irq_src_latch.sv
module grp_irq_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic en_i,
    input  logic clr_i,
    output logic pend_o
);
    logic src_q;
    logic pend_q;
    logic set_w;

    assign set_w  = src_i & ~src_q & en_i;
    assign pend_o = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            src_q  <= src_i;
            pend_q <= set_w | (pend_q & ~clr_i);
        end
    end

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);

    // R5
    set_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |=> pend_q);

    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !(src_i && en_i)) |=> !pend_q);

endmodule

// File: rtl/grp_irq_group_or.sv
module grp_irq_group_or #(
    parameter int WIDTH = 1
) (
    input  logic [WIDTH-1:0] pend_i,
    output logic             irq_o
);
    assign irq_o = |pend_i;
endmodule

// File: rtl/grp_irq_regif.sv
module grp_irq_regif
    import grp_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_SRC  = NUM_SRC,
    parameter int N_EN   = EN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [N_SRC-1:0]  pend_i,
    output logic [N_SRC-1:0]  clr_o,
    output logic [N_EN-1:0]   en_n_o,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    port_state_e       state_q, state_d;
    logic              rd_req;
    logic              hit_pend, hit_en;
    logic [N_EN-1:0]   en_n_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign rd_req   = req_valid && !req_write;
    assign hit_pend = (req_addr == ADDR_W'(OFS_PEND));
    assign hit_en   = (req_addr == ADDR_W'(OFS_ENABLE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: state_d = rd_req ? PORT_RESP : PORT_IDLE;
            PORT_RESP: state_d = rd_req ? PORT_RESP : PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rsp_valid = 1'b0;
        unique case (state_q)
            PORT_IDLE: rsp_valid = 1'b0;
            PORT_RESP: rsp_valid = 1'b1;
            default:   rsp_valid = 1'b0;
        endcase
    end
    assign rsp_rdata = rdata_q;

    always_comb begin
        rd_mux = '0;
        if (hit_pend)    rd_mux[N_SRC-1:0] = pend_i;
        else if (hit_en) rd_mux[N_EN-1:0]  = en_n_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_n_q <= '1;
        else if (req_valid && req_write && hit_en) en_n_q <= req_wdata[N_EN-1:0];
    end
    assign en_n_o = en_n_q;

    always_comb begin
        clr_o = '0;
        if (req_valid && req_write && hit_pend) clr_o = ~req_wdata[N_SRC-1:0];
    end

    // R9
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);

    // R9
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[DATA_W-1:N_SRC] == '0));

endmodule

// File: rtl/grp_irq_top.sv
module grp_irq_top
    import grp_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [NUM_GRP-1:0] irq_o
);
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] clr_w;
    logic [NUM_SRC-1:0] en_w;
    logic [NUM_SRC-1:0] live_w;
    logic [EN_W-1:0]    en_n_w;

    grp_irq_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_SRC  (NUM_SRC),
        .N_EN   (EN_W)
    ) regif_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pend_i    (pend_w),
        .clr_o     (clr_w),
        .en_n_o    (en_n_w),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i < EN_W) begin : g_gated
            assign en_w[i] = ~en_n_w[i];
        end else begin : g_open
            assign en_w[i] = 1'b1;
        end
        grp_irq_src_latch latch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[i]),
            .en_i   (en_w[i]),
            .clr_i  (clr_w[i]),
            .pend_o (pend_w[i])
        );
    end

    assign live_w = pend_w & en_w;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LO = grp_lo(g);
        localparam int HI = grp_hi(g);
        grp_irq_group_or #(.WIDTH(HI - LO + 1)) or_i (
            .pend_i (live_w[HI:LO]),
            .irq_o  (irq_o[g])
        );
    end

    // R7
    upper_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w[NUM_SRC-1:EN_W] != '0) |-> (irq_o[NUM_GRP-1:1] != '0));

endmodule

// File: tb/grp_irq_top_tb_top.sv
module grp_irq_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] src_i = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  irq_o;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_irq_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_o(irq_o)
    );

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R9 unexpected rsp_valid: actual=%h expected=no response", rsp_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    bad++;
                    $display("FAIL %s read: actual=%h expected=%h", t, rsp_rdata, e);
                end
            end
        end
    end

    // all tasks start just after a falling edge
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic pulse(input int i);
        src_i[i] = 1'b1;
        @(negedge clk);
        src_i[i] = 1'b0;
    endtask

    task automatic chk_irq(input logic [3:0] e, input string t);
        total++;
        if (irq_o !== e) begin
            bad++;
            $display("FAIL %s irq_o: actual=%b expected=%b", t, irq_o, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk_irq(4'b0000, "R1");
        rd(8'h04, 32'h0, "R1");
        rd(8'h08, 32'h7F, "R1");
        // R2 R3 R7: group 1 source
        pulse(8);
        chk_irq(4'b0010, "R3");
        rd(8'h04, 32'h100, "R2");
        // R6: disabled source ignored
        pulse(2);
        chk_irq(4'b0010, "R6");
        rd(8'h04, 32'h100, "R6");
        wr(8'h08, 32'h7B);
        rd(8'h08, 32'h7B, "R6");
        pulse(2);
        chk_irq(4'b0011, "R6");
        rd(8'h04, 32'h104, "R2");
        // R4: write-zero-to-clear, ones ignored
        wr(8'h04, 32'hFFFF_FEFF);
        chk_irq(4'b0001, "R4");
        rd(8'h04, 32'h004, "R4");
        // R6: pending but disabled stops driving output
        wr(8'h08, 32'h7F);
        chk_irq(4'b0000, "R6");
        rd(8'h04, 32'h004, "R6");
        wr(8'h08, 32'h7B);
        chk_irq(4'b0001, "R6");
        wr(8'h04, 32'hFFFF_FFFB);
        chk_irq(4'b0000, "R4");
        // R5: edge and clear in the same cycle
        src_i[10] = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_wdata = 32'h0;
        @(negedge clk);
        src_i[10] = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        chk_irq(4'b0100, "R5");
        rd(8'h04, 32'h400, "R5");
        // R10: held level sets once
        src_i[15] = 1'b1;
        @(negedge clk);
        chk_irq(4'b1100, "R3");
        wr(8'h04, 32'h0);
        @(negedge clk);
        chk_irq(4'b0000, "R10");
        rd(8'h04, 32'h0, "R10");
        src_i[15] = 1'b0;
        @(negedge clk);
        src_i[15] = 1'b1;
        @(negedge clk);
        chk_irq(4'b1000, "R10");
        // R7: upper enable bits not stored, upper groups open
        wr(8'h08, 32'hFFFF_FF80);
        rd(8'h08, 32'h0, "R7");
        pulse(10);
        chk_irq(4'b1100, "R7");
        pulse(0);
        chk_irq(4'b1101, "R3");
        rd(8'h04, 32'h8401, "R2");
        // R8: unmapped offsets
        wr(8'h10, 32'h0);
        rd(8'h04, 32'h8401, "R8");
        rd(8'h00, 32'h0, "R8");
        rd(8'h0C, 32'h0, "R8");
        // R9: back-to-back reads
        rd(8'h04, 32'h8401, "R9");
        rd(8'h08, 32'h0, "R9");
        repeat (2) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R9 missing responses: actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule